// File: doc/BRIEF.md
# Byte-Window Instruction Memory Loader

This block gives a host a narrow, byte-wide path into the 32-bit instruction store of a small microsequencer. The host selects one of four registers with a 2-bit register select. Two of them form a 9-bit word pointer: a low byte plus one usable bit in a high register. One is a control register. The last is a data port. Each access to the data port moves one byte lane, least significant first. After the fourth lane the pointer steps to the next word. Writes collect the three lower bytes in a staging register. The whole word reaches the store when the top byte arrives.

The data port works only while the load-enable control bit is set. A second control bit drives a reset line for the sequencer. The sequencer core itself lies outside this block. It sees only a fetch port with a registered, one-cycle read of any word.

Lane tracking is a four-state machine. Its states are LANE_B0, LANE_B1, LANE_B2 and LANE_B3. It has three transitions:
- ADVANCE: an enabled data access moves to the next lane, and LANE_B3 goes back to LANE_B0.
- RESTART: a write to either pointer register forces LANE_B0.
- HOLD: any other cycle keeps the current lane.

Top module: `iram_byte_loader`

## Requirements
- R1: After reset the control register reads 0x00, both pointer registers read 0x00, `seq_rst` is low and the lane is LANE_B0.
- R2: Control register (select 0): bit 0 is load enable and bit 1 is sequencer reset. It reads back as written in those two bits and as zero elsewhere. `seq_rst` equals bit 1.
- R3: Select 2 is the pointer low byte. Select 3 is the pointer high register, of which only bit 0 is stored. Its other bits always read zero. The word pointer is {high bit 0, low byte}.
- R4: Data-port writes (select 1) with load enabled take bytes least significant first. The word is written to the store only on the fourth byte. After three bytes the stored word is unchanged.
- R5: The word pointer steps by one only after the fourth data-port access of a word.
- R6: The word pointer wraps from 511 to 0.
- R7: A write to select 2 or select 3 returns the lane to LANE_B0.
- R8: Data-port reads return lane n of the pointed word (byte n = bits 8n+7..8n), and each read moves to the next lane.
- R9: With load enable clear, data-port writes leave the store unchanged, no data-port access moves the lane or the pointer, and data-port reads return 0x00.
- R10: `fetch_word` shows the word at `fetch_addr` one clock later. If a commit to the same word falls in that cycle, the old word is returned.
- R11: When `host_wr` and `host_rd` are both high on the data port, only the write is performed and the lane advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (lane side effect on data port) |
| host_sel | input | 2 | Register select: 0 control, 1 data, 2 pointer low, 3 pointer high |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Selected register byte, combinational |
| seq_rst | output | 1 | Sequencer reset from control bit 1 |
| fetch_addr | input | 9 | Sequencer fetch word address |
| fetch_word | output | 32 | Registered fetch result |

## Verification
Two activities can land on the same edge. In one, the host's fourth byte commits a word while the sequencer fetches that same address. The bench stages three bytes, then presents the fourth byte and the matching fetch address in one cycle. It expects the previous word on that edge and the new word one fetch later. In the other, a host read and a host write hit the data port together. Four such cycles must leave exactly one written word and a pointer that moved by one.

// File: rtl/iram_pkg.sv
package iram_pkg;
    localparam int WORD_BYTES = 4;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = WORD_BYTES * BYTE_W;
    localparam int PTR_W      = 9;
    localparam int LANE_W     = $clog2(WORD_BYTES);

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DATA = 2'd1,
        SEL_PLO  = 2'd2,
        SEL_PHI  = 2'd3
    } sel_e;

    typedef enum logic [LANE_W-1:0] {
        LANE_B0 = 2'd0,
        LANE_B1 = 2'd1,
        LANE_B2 = 2'd2,
        LANE_B3 = 2'd3
    } lane_e;
endpackage

// File: rtl/iram_lane_fsm.sv
module iram_lane_fsm
    import iram_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    input  logic  restart,
    output lane_e lane,
    output logic  word_done
);
    lane_e lane_q, lane_d;

    always_ff @(posedge clk) begin
        if (!rst_n) lane_q <= LANE_B0;
        else        lane_q <= lane_d;
    end

    always_comb begin
        lane_d = lane_q;
        if (restart) begin
            lane_d = LANE_B0;
        end else if (step) begin
            unique case (lane_q)
                LANE_B0: lane_d = LANE_B1;
                LANE_B1: lane_d = LANE_B2;
                LANE_B2: lane_d = LANE_B3;
                LANE_B3: lane_d = LANE_B0;
            endcase
        end
    end

    assign lane      = lane_q;
    assign word_done = step && !restart && (lane_q == LANE_B3);

    assert_lane_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> $stable(lane_q));
    assert_lane_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (lane_q == LANE_B0));
    assert_lane_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> (lane_q == LANE_B0));
endmodule

// File: rtl/iram_ptr_regs.sv
module iram_ptr_regs
    import iram_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  sel_e             sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic             bump,
    output logic [PTR_W-1:0] ptr,
    output logic             load_en,
    output logic             seq_reset
);
    logic [PTR_W-1:0] ptr_q;
    logic             load_q, srst_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            load_q <= 1'b0;
            srst_q <= 1'b0;
        end else begin
            if (wr && sel == SEL_CTRL) begin
                load_q <= wdata[0];
                srst_q <= wdata[1];
            end
            if (wr && sel == SEL_PLO)      ptr_q[7:0] <= wdata;
            else if (wr && sel == SEL_PHI) ptr_q[8]   <= wdata[0];
            else if (bump)                 ptr_q      <= ptr_q + 1'b1;
        end
    end

    assign ptr       = ptr_q;
    assign load_en   = load_q;
    assign seq_reset = srst_q;

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && !wr) |=> (ptr_q == PTR_W'($past(ptr_q) + 1)));
    assert_ptr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bump && !wr) |=> $stable(ptr_q));
endmodule

// File: rtl/iram_store.sv
module iram_store
    import iram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_we,
    input  logic              load_en,
    input  lane_e             lane,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [PTR_W-1:0]  fetch_addr,
    output logic [BYTE_W-1:0] lane_byte,
    output logic [WORD_W-1:0] fetch_word
);
    localparam int DEPTH = 1 << PTR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] stage [WORD_BYTES-1];
    logic [WORD_W-1:0] cur_word;
    logic              commit;

    assign commit = byte_we && (lane == LANE_B3);

    generate
        for (genvar g = 0; g < WORD_BYTES - 1; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n)                                  stage[g] <= '0;
                else if (byte_we && lane == lane_e'(g))      stage[g] <= wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (commit) mem[ptr] <= {wdata, stage[2], stage[1], stage[0]};
        fetch_word <= mem[fetch_addr];
    end

    assign cur_word  = mem[ptr];
    assign lane_byte = cur_word[lane*BYTE_W +: BYTE_W];

    assert_commit_needs_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> load_en);
endmodule

// File: rtl/iram_byte_loader.sv
module iram_byte_loader
    import iram_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [1:0]  host_sel,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        seq_rst,
    input  logic [8:0]  fetch_addr,
    output logic [31:0] fetch_word
);
    sel_e             sel;
    lane_e            lane;
    logic             load_en, word_done, data_wr, data_rd, ptr_wr;
    logic [PTR_W-1:0] ptr;
    logic [BYTE_W-1:0] lane_byte;

    assign sel     = sel_e'(host_sel);
    assign data_wr = host_wr && sel == SEL_DATA && load_en;
    assign data_rd = host_rd && !host_wr && sel == SEL_DATA && load_en;
    assign ptr_wr  = host_wr && (sel == SEL_PLO || sel == SEL_PHI);

    iram_lane_fsm u_lane (
        .clk(clk), .rst_n(rst_n), .step(data_wr || data_rd),
        .restart(ptr_wr), .lane(lane), .word_done(word_done)
    );

    iram_ptr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(host_wr), .sel(sel), .wdata(host_wdata),
        .bump(word_done), .ptr(ptr), .load_en(load_en), .seq_reset(seq_rst)
    );

    iram_store u_store (
        .clk(clk), .rst_n(rst_n), .byte_we(data_wr), .load_en(load_en),
        .lane(lane), .wdata(host_wdata), .ptr(ptr), .fetch_addr(fetch_addr),
        .lane_byte(lane_byte), .fetch_word(fetch_word)
    );

    always_comb begin
        unique case (sel)
            SEL_CTRL: host_rdata = {6'b0, seq_rst, load_en};
            SEL_DATA: host_rdata = load_en ? lane_byte : 8'h00;
            SEL_PLO:  host_rdata = ptr[7:0];
            SEL_PHI:  host_rdata = {7'b0, ptr[8]};
        endcase
    end

    always_comb begin
        if (rst_n && sel == SEL_PHI)
            assert_phi_upper_zero_R3: assert (host_rdata[7:1] == 7'b0);
    end

    assert_ctrl_srst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && sel == SEL_CTRL) |=> (seq_rst == $past(host_wdata[1])));
endmodule

// File: tb/iram_byte_loader_tb.sv
module iram_byte_loader_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 0, rst_n = 0;
    logic        host_wr = 0, host_rd = 0;
    logic [1:0]  host_sel = 0;
    logic [7:0]  host_wdata = 0;
    logic [7:0]  host_rdata;
    logic        seq_rst;
    logic [8:0]  fetch_addr = 0;
    logic [31:0] fetch_word;

    int n_chk = 0, n_fail = 0, cycles = 0;

    iram_byte_loader dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] s, logic [7:0] d);
        @(negedge clk);
        host_sel = s; host_wdata = d; host_wr = 1;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd(logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        host_sel = s; host_rd = 1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic peek(logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        host_sel = s;
        #1 d = host_rdata;
    endtask

    task automatic fetch(logic [8:0] a, output logic [31:0] w);
        @(negedge clk);
        fetch_addr = a;
        @(negedge clk);
        w = fetch_word;
    endtask

    task automatic set_ptr(logic [8:0] a);
        wr(2'd2, a[7:0]);
        wr(2'd3, {7'b0, a[8]});
    endtask

    task automatic put_word(logic [31:0] w);
        for (int i = 0; i < 4; i++) wr(2'd1, w[i*8 +: 8]);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        peek(2'd0, v); chk("R1 ctrl", v, 0);
        peek(2'd2, v); chk("R1 plo", v, 0);
        peek(2'd3, v); chk("R1 phi", v, 0);
        chk("R1 seq_rst", seq_rst, 0);
    endtask

    task automatic t_ctrl;
        logic [7:0] v;
        wr(2'd0, 8'hFF);
        peek(2'd0, v); chk("R2 ctrl readback", v, 8'h03);
        chk("R2 seq_rst high", seq_rst, 1);
        wr(2'd0, 8'h01);
        peek(2'd0, v); chk("R2 ctrl load only", v, 8'h01);
        chk("R2 seq_rst low", seq_rst, 0);
    endtask

    task automatic t_ptr;
        logic [7:0] v;
        wr(2'd2, 8'h05); wr(2'd3, 8'hFF);
        peek(2'd3, v); chk("R3 phi one bit", v, 8'h01);
        peek(2'd2, v); chk("R3 plo", v, 8'h05);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_write;
        logic [7:0] v; logic [31:0] w;
        set_ptr(9'd5);
        put_word(32'h11223344);
        peek(2'd2, v); chk("R5 step after word", v, 8'h06);
        fetch(9'd5, w); chk("R4 word committed", w, 32'h11223344);
        set_ptr(9'd5);
        wr(2'd1, 8'hAA); wr(2'd1, 8'hBB); wr(2'd1, 8'hCC);
        fetch(9'd5, w); chk("R4 no commit before fourth", w, 32'h11223344);
        peek(2'd2, v); chk("R5 no step mid word", v, 8'h05);
    endtask

    task automatic t_restart;
        logic [31:0] w;
        wr(2'd2, 8'h05);
        put_word(32'h04030201);
        fetch(9'd5, w); chk("R7 lane restarted", w, 32'h04030201);
    endtask

    task automatic t_read;
        logic [7:0] v;
        set_ptr(9'd5);
        for (int i = 0; i < 4; i++) begin
            rd(2'd1, v); chk("R8 lane byte", v, 8'(i + 1));
        end
        peek(2'd2, v); chk("R8 step after read", v, 8'h06);
    endtask

    task automatic t_wrap;
        logic [7:0] v; logic [31:0] w;
        set_ptr(9'd511);
        put_word(32'hDEADBEEF);
        peek(2'd2, v); chk("R6 wrap lo", v, 8'h00);
        peek(2'd3, v); chk("R6 wrap hi", v, 8'h00);
        fetch(9'd511, w); chk("R6 last word", w, 32'hDEADBEEF);
    endtask

    task automatic t_disabled;
        logic [7:0] v; logic [31:0] w;
        set_ptr(9'd5);
        wr(2'd0, 8'h00);
        for (int i = 0; i < 4; i++) wr(2'd1, 8'h77);
        rd(2'd1, v); chk("R9 read zero", v, 8'h00);
        peek(2'd2, v); chk("R9 ptr unmoved", v, 8'h05);
        fetch(9'd5, w); chk("R9 store unchanged", w, 32'h04030201);
        wr(2'd0, 8'h01);
        rd(2'd1, v); chk("R9 lane unmoved", v, 8'h01);
    endtask

    task automatic t_collide;
        logic [31:0] w;
        set_ptr(9'd7);
        put_word(32'h99887766);
        set_ptr(9'd7);
        wr(2'd1, 8'h10); wr(2'd1, 8'h20); wr(2'd1, 8'h30);
        @(negedge clk);
        host_sel = 2'd1; host_wdata = 8'h40; host_wr = 1; fetch_addr = 9'd7;
        @(negedge clk);
        host_wr = 0;
        chk("R10 old word on commit edge", fetch_word, 32'h99887766);
        @(negedge clk);
        chk("R10 new word next fetch", fetch_word, 32'h40302010);
    endtask

    task automatic t_both;
        logic [7:0] v; logic [31:0] w;
        set_ptr(9'd8);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            host_sel = 2'd1; host_wdata = 8'hA0 + 8'(i); host_wr = 1; host_rd = 1;
            @(negedge clk);
            host_wr = 0; host_rd = 0;
        end
        peek(2'd2, v); chk("R11 single step", v, 8'h09);
        fetch(9'd8, w); chk("R11 write wins", w, 32'hA3A2A1A0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_ctrl;
        t_ptr;
        t_write;
        t_restart;
        t_read;
        t_wrap;
        t_disabled;
        t_collide;
        t_both;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule